// File: doc/BRIEF.md
# Stereo I2S Channel Sample FIFOs and Interrupt Registers

This block is the register-facing half of one stereo audio serial channel. Software reaches it through a small memory-mapped bus with a 64-byte window. Left and right samples live in separate FIFOs. Software writes outgoing samples through a left holding register and a right holding register. Reads from those same two registers return incoming samples.

On the sample side, a serializer receives one outgoing frame at a time through a valid/take handshake. The serializer also pushes one incoming left/right pair per frame.

The block keeps the per-channel interrupt status and applies a mask to it. It compares FIFO fill levels against thresholds that software programs as level minus one. It also flushes FIFOs on command and records overruns in sticky flags. Reading a dedicated register clears each flag.

Top module: `i2s_chan`

## Requirements
- R1: After reset:
  - all FIFOs are empty and both overrun flags are clear;
  - every enable is 0 and both thresholds are 0;
  - the mask register (0x34) reads 0x33, irq is low and tx_valid is low.
- R2: A write to 0x20 pushes bus_wdata into the left transmit FIFO, and a write to 0x24 pushes into the right one. The two FIFOs fill independently of each other.
  - tx_valid is high only while both transmit FIFOs hold data and the transmit path is enabled.
  - tx_left and tx_right show the oldest entries.
  - A cycle with tx_take high while tx_valid is high pops one entry from each transmit FIFO.
- R3: A cycle with rx_push high stores rx_left and rx_right as one frame. A read of 0x20 pops the oldest left receive sample, and a read of 0x24 pops the oldest right one, each FIFO in arrival order.
- R4: A read of 0x20 or 0x24 while that receive FIFO is empty returns 0 and changes no FIFO state.
- R5: Status register 0x30 bit 4 is 1 while the left transmit FIFO fill is at or below the transmit threshold register (0x0C) plus one.
- R6: Status bit 0 is 1 while the left receive FIFO fill is at or above the receive threshold register (0x18) plus one.
- R7: Overruns drop data and raise a flag:
  - a write to a full transmit FIFO discards the data and sets status bit 5;
  - an enabled rx_push while either receive FIFO is full discards the whole frame and sets status bit 1.
- R8: Reading 0x3C returns the transmit overrun flag in bit 0 and then clears it. Reading 0x38 does the same for the receive overrun flag. Both flags otherwise stay set.
- R9: irq is high exactly when some status bit (5, 4, 1 or 0) is 1 while its mask bit in 0x34 is 0.
- R10: Writing 1 in bit 0 empties FIFOs:
  - to 0x14, both transmit FIFOs;
  - to 0x10, both receive FIFOs.
- R11: The read-only parameter register 0x1C returns the FIFO depth code k in bits 3:2, where depth = 2^(k+1).
- R12: Transmit needs the global enable (0x00), the transmit block enable (0x08) and the transmit channel enable (0x2C) all at 1 before tx_valid can rise. Receive needs the global enable, the receive block enable (0x04) and the receive channel enable (0x28) all at 1. Otherwise rx_push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access |
| tx_valid | output | 1 | An outgoing frame is available |
| tx_take | input | 1 | Serializer consumes the offered frame |
| tx_left | output | DW | Left sample of the offered frame |
| tx_right | output | DW | Right sample of the offered frame |
| rx_push | input | 1 | Serializer delivers one incoming frame |
| rx_left | input | DW | Incoming left sample |
| rx_right | input | DW | Incoming right sample |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions take several things about the inputs for granted:
- every bus access lasts one cycle and uses a word-aligned offset;
- rx_push and tx_take are single-cycle pulses whose values are known at each rising edge.

The properties on overrun flags, flushing and empty reads also assume that a flush write and a holding-register access never fall in the same cycle. The stimulus respects all of this: it drives every input on the falling edge, performs one access or one sample-side pulse at a time, and returns each strobe to 0 before the next operation.

// File: rtl/i2s_chan_pkg.sv
// Package: register offsets and status bit positions for the stereo channel.
// Assumes a 64-byte per-channel window addressed by byte offset.
package i2s_chan_pkg;
    localparam logic [5:0] A_GEN_EN    = 6'h00;
    localparam logic [5:0] A_RXB_EN    = 6'h04;
    localparam logic [5:0] A_TXB_EN    = 6'h08;
    localparam logic [5:0] A_TX_THR    = 6'h0C;
    localparam logic [5:0] A_RX_FLUSH  = 6'h10;
    localparam logic [5:0] A_TX_FLUSH  = 6'h14;
    localparam logic [5:0] A_RX_THR    = 6'h18;
    localparam logic [5:0] A_PARAM     = 6'h1C;
    localparam logic [5:0] A_HOLD_L    = 6'h20;
    localparam logic [5:0] A_HOLD_R    = 6'h24;
    localparam logic [5:0] A_RXC_EN    = 6'h28;
    localparam logic [5:0] A_TXC_EN    = 6'h2C;
    localparam logic [5:0] A_STATUS    = 6'h30;
    localparam logic [5:0] A_MASK      = 6'h34;
    localparam logic [5:0] A_RX_OVCLR  = 6'h38;
    localparam logic [5:0] A_TX_OVCLR  = 6'h3C;

    localparam int ST_RXDA = 0;
    localparam int ST_RXOV = 1;
    localparam int ST_TXE  = 4;
    localparam int ST_TXOV = 5;

    localparam logic [5:0] MASK_RESET = 6'b110011;
endpackage

// File: rtl/i2s_lr_fifo.sv
// Module: single-clock sample FIFO used for one audio slot (left or right).
// Assumes DEPTH is a power of two; a push when full and a pop when empty
// are ignored here, the caller decides how to report them. Flush wins.
module i2s_lr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign rdata = mem[rp];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    // Pointer and fill-count maintenance, with flush clearing everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= wp + AW'(1);
            if (rd_ok) rp <= rp + AW'(1);
            if (wr_ok && !rd_ok)      count <= count + CW'(1);
            else if (rd_ok && !wr_ok) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/i2s_irq_unit.sv
// Module: sticky overrun flags, interrupt mask register and masked request.
// Assumes level conditions (txe, rxda) arrive already computed; a set
// and a clear of the same flag in one cycle leaves the flag set.
module i2s_irq_unit
    import i2s_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txe,
    input  logic       rxda,
    input  logic       tx_ovf_set,
    input  logic       rx_ovf_set,
    input  logic       tx_ovf_clr,
    input  logic       rx_ovf_clr,
    input  logic       mask_we,
    input  logic [5:0] mask_wdata,
    output logic [5:0] status,
    output logic [5:0] mask,
    output logic       irq
);
    logic tx_ovf_q, rx_ovf_q;

    // Overrun flags: set on a dropped transfer, clear on the dedicated read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            if (tx_ovf_set)      tx_ovf_q <= 1'b1;
            else if (tx_ovf_clr) tx_ovf_q <= 1'b0;
            if (rx_ovf_set)      rx_ovf_q <= 1'b1;
            else if (rx_ovf_clr) rx_ovf_q <= 1'b0;
        end
    end

    // Mask register: only the four defined bit positions are writable.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= MASK_RESET;
        else if (mask_we) mask <= mask_wdata & MASK_RESET;
    end

    // Assemble the status vector at its fixed bit positions.
    always_comb begin
        status          = '0;
        status[ST_RXDA] = rxda;
        status[ST_RXOV] = rx_ovf_q;
        status[ST_TXE]  = txe;
        status[ST_TXOV] = tx_ovf_q;
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/i2s_chan.sv
// Module: one stereo audio channel as seen from a 64-byte register window.
// Holds left/right transmit and receive FIFOs, thresholds, enables,
// flush commands and interrupt status. Assumes one-cycle bus accesses,
// DW <= 32, and that read side effects happen at the access's clock edge.
module i2s_chan
    import i2s_chan_pkg::*;
#(
    parameter int DW     = 32,
    parameter int FIFO_K = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [5:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          tx_valid,
    input  logic          tx_take,
    output logic [DW-1:0] tx_left,
    output logic [DW-1:0] tx_right,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_left,
    input  logic [DW-1:0] rx_right,
    output logic          irq
);
    localparam int DEPTH = 2 ** (FIFO_K + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;

    logic          wr, rd;
    logic          gen_en, rxb_en, txb_en, rxc_en, txc_en;
    logic [AW-1:0] tx_thr, rx_thr;
    logic          tx_path, rx_path;
    logic          tx_flush, rx_flush;
    logic [CW-1:0] txl_cnt, txr_cnt, rxl_cnt, rxr_cnt;
    logic          txl_full, txr_full, rxl_full, rxr_full;
    logic          txl_empty, txr_empty, rxl_empty, rxr_empty;
    logic [DW-1:0] rxl_data, rxr_data;
    logic          rx_accept, rx_full_any;
    logic          txe, rxda;
    logic [5:0]    status, mask;

    assign wr = bus_en && bus_we;
    assign rd = bus_en && !bus_we;

    // Control registers: enables and thresholds (stored as level minus one).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            rxb_en <= 1'b0;
            txb_en <= 1'b0;
            rxc_en <= 1'b0;
            txc_en <= 1'b0;
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_GEN_EN: gen_en <= bus_wdata[0];
                A_RXB_EN: rxb_en <= bus_wdata[0];
                A_TXB_EN: txb_en <= bus_wdata[0];
                A_RXC_EN: rxc_en <= bus_wdata[0];
                A_TXC_EN: txc_en <= bus_wdata[0];
                A_TX_THR: tx_thr <= bus_wdata[AW-1:0];
                A_RX_THR: rx_thr <= bus_wdata[AW-1:0];
                default:  ;
            endcase
        end
    end

    assign tx_path     = gen_en && txb_en && txc_en;
    assign rx_path     = gen_en && rxb_en && rxc_en;
    assign tx_flush    = wr && (bus_addr == A_TX_FLUSH) && bus_wdata[0];
    assign rx_flush    = wr && (bus_addr == A_RX_FLUSH) && bus_wdata[0];
    assign tx_valid    = tx_path && !txl_empty && !txr_empty;
    assign rx_full_any = rxl_full || rxr_full;
    assign rx_accept   = rx_push && rx_path && !rx_full_any;

    i2s_lr_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_l (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(wr && bus_addr == A_HOLD_L), .wdata(bus_wdata[DW-1:0]),
        .pop(tx_take && tx_valid), .rdata(tx_left),
        .count(txl_cnt), .full(txl_full), .empty(txl_empty));

    i2s_lr_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_r (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(wr && bus_addr == A_HOLD_R), .wdata(bus_wdata[DW-1:0]),
        .pop(tx_take && tx_valid), .rdata(tx_right),
        .count(txr_cnt), .full(txr_full), .empty(txr_empty));

    i2s_lr_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_l (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_accept), .wdata(rx_left),
        .pop(rd && bus_addr == A_HOLD_L), .rdata(rxl_data),
        .count(rxl_cnt), .full(rxl_full), .empty(rxl_empty));

    i2s_lr_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_r (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_accept), .wdata(rx_right),
        .pop(rd && bus_addr == A_HOLD_R), .rdata(rxr_data),
        .count(rxr_cnt), .full(rxr_full), .empty(rxr_empty));

    assign txe  = (txl_cnt <= (CW'(tx_thr) + CW'(1)));
    assign rxda = (rxl_cnt >= (CW'(rx_thr) + CW'(1)));

    i2s_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n), .txe(txe), .rxda(rxda),
        .tx_ovf_set((wr && bus_addr == A_HOLD_L && txl_full) ||
                    (wr && bus_addr == A_HOLD_R && txr_full)),
        .rx_ovf_set(rx_push && rx_path && rx_full_any),
        .tx_ovf_clr(rd && bus_addr == A_TX_OVCLR),
        .rx_ovf_clr(rd && bus_addr == A_RX_OVCLR),
        .mask_we(wr && bus_addr == A_MASK), .mask_wdata(bus_wdata[5:0]),
        .status(status), .mask(mask), .irq(irq));

    // Read data mux; empty receive FIFOs read as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_GEN_EN:   bus_rdata = 32'(gen_en);
            A_RXB_EN:   bus_rdata = 32'(rxb_en);
            A_TXB_EN:   bus_rdata = 32'(txb_en);
            A_RXC_EN:   bus_rdata = 32'(rxc_en);
            A_TXC_EN:   bus_rdata = 32'(txc_en);
            A_TX_THR:   bus_rdata = 32'(tx_thr);
            A_RX_THR:   bus_rdata = 32'(rx_thr);
            A_PARAM:    bus_rdata = 32'(FIFO_K) << 2;
            A_HOLD_L:   bus_rdata = rxl_empty ? '0 : 32'(rxl_data);
            A_HOLD_R:   bus_rdata = rxr_empty ? '0 : 32'(rxr_data);
            A_STATUS:   bus_rdata = 32'(status);
            A_MASK:     bus_rdata = 32'(mask);
            A_RX_OVCLR: bus_rdata = 32'(status[ST_RXOV]);
            A_TX_OVCLR: bus_rdata = 32'(status[ST_TXOV]);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2s_chan_chk.sv
// Module: property checker for i2s_chan, bound into every instance.
// Assumes one-cycle bus strobes and known inputs at each rising edge.
module i2s_chan_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic [5:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          tx_valid,
    input logic          rx_push,
    input logic          rx_path,
    input logic          irq,
    input logic [CW-1:0] txl_cnt,
    input logic [CW-1:0] txr_cnt,
    input logic [CW-1:0] rxl_cnt,
    input logic [5:0]    status,
    input logic [5:0]    mask
);
    logic rd_l, rd_txov;
    assign rd_l    = bus_en && !bus_we && bus_addr == 6'h20;
    assign rd_txov = bus_en && !bus_we && bus_addr == 6'h3C;

    AST_TXVALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (txl_cnt != '0 && txr_cnt != '0)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (txl_cnt <= CW'(DEPTH)) && (rxl_cnt <= CW'(DEPTH))); // R7
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_l && rxl_cnt == '0) |-> bus_rdata == 32'd0); // R4
    AST_EMPTY_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_l && rxl_cnt == '0 && !rx_push) |=> rxl_cnt == '0); // R4
    AST_TXOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !rd_txov) |=> status[5]); // R8
    AST_TXOV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_txov |=> !status[5]); // R8
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 6'h14 && bus_wdata[0])
        |=> (txl_cnt == '0 && txr_cnt == '0)); // R10
    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 6'h33) |-> !irq); // R9
    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_path) |=> rxl_cnt <= $past(rxl_cnt)); // R12
endmodule

bind i2s_chan i2s_chan_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .rx_push(rx_push), .rx_path(rx_path), .irq(irq),
    .txl_cnt(txl_cnt), .txr_cnt(txr_cnt), .rxl_cnt(rxl_cnt),
    .status(status), .mask(mask));

// File: tb/tb_i2s_chan.sv
// Bench: sweeps thresholds against every fill level of an 8-deep channel
// and checks data order, overruns, flushes, masking and enables.
module tb_i2s_chan;
    localparam int DW     = 32;
    localparam int FIFO_K = 2;
    localparam int DEPTH  = 2 ** (FIFO_K + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          tx_valid, tx_take = 1'b0;
    logic [DW-1:0] tx_left, tx_right;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_left = '0, rx_right = '0;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    i2s_chan #(.DW(DW), .FIFO_K(FIFO_K)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic push(logic [31:0] l, logic [31:0] r);
        @(negedge clk);
        rx_push = 1'b1; rx_left = l; rx_right = r;
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic take();
        @(negedge clk);
        tx_take = 1'b1;
        @(posedge clk); #1;
        tx_take = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 irq", 32'(irq), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        rd(6'h30, v); check("R1 status", v, 32'h10);
        rd(6'h34, v); check("R1 mask", v, 32'h33);
        rd(6'h20, v); check("R4 empty left read", v, 0);
        rd(6'h00, v); check("R1 global enable", v, 0);
        // R11: depth code
        rd(6'h1C, v); check("R11 param", v, 32'(FIFO_K) << 2);

        // Enable both paths
        wr(6'h00, 1); wr(6'h04, 1); wr(6'h08, 1); wr(6'h28, 1); wr(6'h2C, 1);
        @(negedge clk); check("R2 empty no valid", 32'(tx_valid), 0);

        // R5: every tx threshold against every fill level
        for (int thr = 0; thr < DEPTH; thr++) begin
            wr(6'h0C, 32'(thr));
            wr(6'h14, 1);
            for (int n = 0; n <= DEPTH; n++) begin
                rd(6'h30, v);
                check("R5 tx empty-to-threshold", 32'(v[4]), 32'(n <= thr + 1));
                if (n < DEPTH) begin
                    wr(6'h20, 32'h100 + 32'(n));
                    wr(6'h24, 32'h200 + 32'(n));
                end
            end
        end

        // R7/R8: overrun on full tx FIFO, clear by read
        wr(6'h20, 32'hDEAD);
        rd(6'h30, v); check("R7 tx overrun flag", 32'(v[5]), 1);
        rd(6'h3C, v); check("R8 tx overrun read", v, 1);
        rd(6'h30, v); check("R8 tx overrun cleared", 32'(v[5]), 0);

        // R2: drain in order, dropped word absent
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            check("R2 tx_valid", 32'(tx_valid), 1);
            check("R2 tx_left", tx_left, 32'h100 + 32'(i));
            check("R2 tx_right", tx_right, 32'h200 + 32'(i));
            take();
        end
        @(negedge clk); check("R2 drained", 32'(tx_valid), 0);

        // R2: left and right fill independently
        wr(6'h20, 32'hA0); wr(6'h20, 32'hA1); wr(6'h20, 32'hA2);
        @(negedge clk); check("R2 left only no valid", 32'(tx_valid), 0);
        wr(6'h24, 32'hB0);
        @(negedge clk);
        check("R2 pair valid", 32'(tx_valid), 1);
        check("R2 pair left", tx_left, 32'hA0);
        // R12: channel enable gates transfer
        wr(6'h2C, 0);
        @(negedge clk); check("R12 tx channel off", 32'(tx_valid), 0);
        wr(6'h2C, 1);
        wr(6'h08, 0);
        @(negedge clk); check("R12 tx block off", 32'(tx_valid), 0);
        wr(6'h08, 1);
        // R10: tx flush
        wr(6'h14, 1);
        @(negedge clk); check("R10 tx flush valid", 32'(tx_valid), 0);
        wr(6'h0C, 0);
        rd(6'h30, v); check("R10 tx flush status", 32'(v[4]), 1);

        // R6: every rx threshold against every fill level
        for (int thr = 0; thr < DEPTH; thr++) begin
            wr(6'h18, 32'(thr));
            wr(6'h10, 1);
            for (int n = 0; n <= DEPTH; n++) begin
                rd(6'h30, v);
                check("R6 rx data available", 32'(v[0]), 32'(n >= thr + 1));
                if (n < DEPTH) push(32'h300 + 32'(n), 32'h400 + 32'(n));
            end
        end

        // R7/R8: rx overrun
        push(32'hBAD0, 32'hBAD1);
        rd(6'h30, v); check("R7 rx overrun flag", 32'(v[1]), 1);
        rd(6'h38, v); check("R8 rx overrun read", v, 1);
        rd(6'h30, v); check("R8 rx overrun cleared", 32'(v[1]), 0);

        // R3: independent ordered reads; R4: empty reads zero
        for (int i = 0; i < DEPTH; i++) begin
            rd(6'h20, v); check("R3 rx left order", v, 32'h300 + 32'(i));
        end
        rd(6'h20, v); check("R4 left empty after drain", v, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(6'h24, v); check("R3 rx right order", v, 32'h400 + 32'(i));
        end
        rd(6'h24, v); check("R4 right empty after drain", v, 0);
        push(32'h55, 32'h66);
        rd(6'h20, v); check("R4 empty read left no state change", v, 32'h55);
        rd(6'h24, v); check("R4 empty read right no state change", v, 32'h66);

        // R9: masking
        @(negedge clk); check("R9 all masked", 32'(irq), 0);
        wr(6'h34, 32'h23);
        @(negedge clk); check("R9 tx empty unmasked", 32'(irq), 1);
        wr(6'h34, 32'h32);
        @(negedge clk); check("R9 rx unmasked idle", 32'(irq), 0);
        wr(6'h18, 0);
        push(32'h77, 32'h88);
        @(negedge clk); check("R9 rx data irq", 32'(irq), 1);
        rd(6'h20, v); rd(6'h24, v);
        @(negedge clk); check("R9 rx drained irq", 32'(irq), 0);

        // R12: rx path disabled ignores pushes
        wr(6'h04, 0);
        push(32'h99, 32'h9A);
        rd(6'h30, v); check("R12 rx disabled status", v[1:0], 0);
        rd(6'h20, v); check("R12 rx disabled data", v, 0);
        wr(6'h04, 1);

        // R10: rx flush
        push(32'h1, 32'h2); push(32'h3, 32'h4);
        wr(6'h10, 1);
        rd(6'h20, v); check("R10 rx flush left", v, 0);
        rd(6'h24, v); check("R10 rx flush right", v, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule